// File: doc/BRIEF.md
# Two-Phase Bus Access Timeout Monitor

This block watches a shared parallel bus for a local master and catches accesses that hang. The first phase covers the wait for the bus: it runs from the master's bus request until the grant arrives. The second phase covers the data transfer itself: it runs from the moment either data strobe goes active until the strobes fall. Each phase has its own programmable limit and its own enable, and the two phases use separate counters.

A free-running prescaler divides the system clock down to a 1 µs tick, and both counters advance only on that tick. Each limit is therefore a count of microseconds. A 50 MHz clock with `TICK_DIV` = 50, an arbitration limit of 32000 and a transfer limit of 256 gives the usual settings: a generous wait for busy backplanes and a transfer window longer than any legitimate access. When a phase expires, the monitor emits a one-cycle bus-error pulse that terminates the access, sets a sticky status bit that software clears by writing one, and raises a timeout flag for that phase. The flag stays high until the phase is left.

An acknowledge or grant that arrives in the same cycle as an expiry wins, and no timeout is reported. Turning off the transfer enable lets a slow access be debugged without the monitor cutting it short.

Top module: `xfer_timeout_monitor`

## Requirements
- R1: While `rst` is high at a clock edge, all outputs are low after that edge, the monitor returns to idle and the prescaler restarts.
- R2: The prescaler issues one tick every `TICK_DIV` clock cycles, and the counters advance only on ticks. With arbitration limit L, the bus-error pulse is seen between (L-1)·TICK_DIV+3 and L·TICK_DIV+2 cycles after the clock edge that first samples the request high with the grant low.
- R3: When the bus is requested, not granted and arbitration checking is enabled, the edge after the tick counter reaches `arb_limit` raises `bus_err` for one cycle, sets `status[0]` and raises `arb_timeout`. The access is abandoned, and `arb_timeout` stays high until `bus_req` drops.
- R4: A grant seen before or in the same cycle as the arbitration expiry ends the arbitration phase without a timeout. The transfer phase then takes over.
- R5: After the grant, either strobe going active starts the transfer counter from zero. If it reaches `xfer_limit` before the strobes fall, `bus_err` pulses, `status[1]` is set and `xfer_timeout` stays high until both strobes are inactive.
- R6: An `xfer_ack` that arrives before or in the same cycle as the transfer expiry completes the transfer, and no timeout is reported.
- R7: When `arb_en` or `xfer_en` is low, the matching phase never times out, however long it lasts.
- R8: Status bits are sticky. A one in bit i of `status_clr` clears `status[i]` (bit 0 arbitration, bit 1 transfer). A new timeout in the same cycle sets the bit, and the set takes priority over the clear.
- R9: The arbitration counter restarts from zero on every new request, and the transfer counter restarts on every new strobe assertion. A fresh request after a timeout therefore gets the full limit again.
- R10: `bus_err` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Local master requests the bus |
| bus_grant | input | 1 | Bus granted to the local master |
| strobe_a | input | 1 | First data strobe, active high |
| strobe_b | input | 1 | Second data strobe, active high |
| xfer_ack | input | 1 | Transfer acknowledge from the target |
| arb_en | input | 1 | Enables the arbitration-phase timeout |
| arb_limit | input | ARB_W | Arbitration limit in ticks |
| xfer_en | input | 1 | Enables the transfer-phase timeout |
| xfer_limit | input | XFER_W | Transfer limit in ticks |
| status_clr | input | 2 | Write-one-to-clear strobes for the status bits |
| arb_timeout | output | 1 | Arbitration phase has expired (held until request drops) |
| xfer_timeout | output | 1 | Transfer phase has expired (held until strobes drop) |
| bus_err | output | 1 | One-cycle error-termination pulse |
| status | output | 2 | Sticky timeout status: bit 0 arbitration, bit 1 transfer |

## Verification
The bench builds the monitor with `TICK_DIV` = 4, a 5-bit arbitration field and a 4-bit transfer field. With these values a tick arrives every few cycles, and even full-scale limits expire within about a hundred cycles. Expiries, the grant and acknowledge races at the exact expiry cycle, and counters running up to their field maximum all occur many times in a short run. A reference model steered by the bench picks out the exact expiry cycle, so the same-cycle priority cases are driven on purpose rather than left to chance.

// File: rtl/xtm_pkg.sv
package xtm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_ARB     = 3'd1,
    PH_OWN     = 3'd2,
    PH_XFER    = 3'd3,
    PH_DONE    = 3'd4,
    PH_ARB_TO  = 3'd5,
    PH_XFER_TO = 3'd6
  } phase_e;

  localparam int NUM_PHASES = 2;
  localparam int IDX_ARB    = 0;
  localparam int IDX_XFER   = 1;

endpackage

// File: rtl/xtm_tick_gen.sv
module xtm_tick_gen #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      tick  <= 1'b0;
    end else if (pre_q == LAST) begin
      pre_q <= '0;
      tick  <= 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
      tick  <= 1'b0;
    end
  end

endmodule

// File: rtl/xtm_tick_counter.sv
module xtm_tick_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         expired
);

  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
    end else if (inc && (cnt_q != CMAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q >= limit);

endmodule

// File: rtl/xtm_phase_ctrl.sv
module xtm_phase_ctrl
  import xtm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  bus_req,
  input  logic                  bus_grant,
  input  logic                  strobe_any,
  input  logic                  xfer_ack,
  input  logic                  arb_en,
  input  logic                  xfer_en,
  input  logic                  arb_expired,
  input  logic                  xfer_expired,
  input  logic [NUM_PHASES-1:0] status_clr,
  output logic                  arb_clr,
  output logic                  arb_inc,
  output logic                  xfer_clr,
  output logic                  xfer_inc,
  output logic                  arb_timeout,
  output logic                  xfer_timeout,
  output logic                  bus_err,
  output logic [NUM_PHASES-1:0] status
);

  phase_e                state_q, state_d;
  logic [NUM_PHASES-1:0] set_d;
  logic                  arb_fire, xfer_fire;
  logic                  arb_flag_d, xfer_flag_d;

  // counter controls derive from the current phase
  assign arb_clr  = (state_q == PH_IDLE);
  assign arb_inc  = (state_q == PH_ARB) && tick && arb_en;
  assign xfer_clr = (state_q != PH_XFER);
  assign xfer_inc = (state_q == PH_XFER) && tick && xfer_en;

  // expiry only counts when the competing completion event is absent
  assign arb_fire  = (state_q == PH_ARB) && bus_req && !bus_grant &&
                     arb_en && arb_expired;
  assign xfer_fire = (state_q == PH_XFER) && !xfer_ack && strobe_any &&
                     xfer_en && xfer_expired;

  always_comb begin
    state_d     = state_q;
    arb_flag_d  = arb_timeout;
    xfer_flag_d = xfer_timeout;
    case (state_q)
      PH_IDLE: begin
        if (bus_req) state_d = PH_ARB;
      end
      PH_ARB: begin
        if (!bus_req)       state_d = PH_IDLE;
        else if (bus_grant) state_d = PH_OWN;
        else if (arb_fire) begin
          state_d    = PH_ARB_TO;
          arb_flag_d = 1'b1;
        end
      end
      PH_ARB_TO: begin
        if (!bus_req) begin
          state_d    = PH_IDLE;
          arb_flag_d = 1'b0;
        end
      end
      PH_OWN: begin
        if (!bus_req)        state_d = PH_IDLE;
        else if (strobe_any) state_d = PH_XFER;
      end
      PH_XFER: begin
        if (xfer_ack)         state_d = PH_DONE;
        else if (!strobe_any) state_d = bus_req ? PH_OWN : PH_IDLE;
        else if (xfer_fire) begin
          state_d     = PH_XFER_TO;
          xfer_flag_d = 1'b1;
        end
      end
      PH_DONE: begin
        if (!strobe_any) state_d = bus_req ? PH_OWN : PH_IDLE;
      end
      PH_XFER_TO: begin
        if (!strobe_any) begin
          state_d     = bus_req ? PH_OWN : PH_IDLE;
          xfer_flag_d = 1'b0;
        end
      end
      default: state_d = PH_IDLE;
    endcase
  end

  always_comb begin
    set_d           = '0;
    set_d[IDX_ARB]  = arb_fire;
    set_d[IDX_XFER] = xfer_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PH_IDLE;
      arb_timeout  <= 1'b0;
      xfer_timeout <= 1'b0;
      bus_err      <= 1'b0;
    end else begin
      state_q      <= state_d;
      arb_timeout  <= arb_flag_d;
      xfer_timeout <= xfer_flag_d;
      bus_err      <= arb_fire || xfer_fire;
    end
  end

  // one sticky bit per phase; a new set beats a clear in the same cycle
  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_status
    always_ff @(posedge clk) begin
      if (rst)           status[i] <= 1'b0;
      else if (set_d[i]) status[i] <= 1'b1;
      else if (status_clr[i]) status[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/xfer_timeout_monitor.sv
module xfer_timeout_monitor #(
  parameter int TICK_DIV = 50,
  parameter int ARB_W    = 16,
  parameter int XFER_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_grant,
  input  logic              strobe_a,
  input  logic              strobe_b,
  input  logic              xfer_ack,
  input  logic              arb_en,
  input  logic [ARB_W-1:0]  arb_limit,
  input  logic              xfer_en,
  input  logic [XFER_W-1:0] xfer_limit,
  input  logic [1:0]        status_clr,
  output logic              arb_timeout,
  output logic              xfer_timeout,
  output logic              bus_err,
  output logic [1:0]        status
);

  logic tick;
  logic arb_clr, arb_inc, arb_expired;
  logic xfer_clr, xfer_inc, xfer_expired;
  logic strobe_any;

  assign strobe_any = strobe_a | strobe_b;

  xtm_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  xtm_tick_counter #(.W(ARB_W)) u_arb_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (arb_clr),
    .inc     (arb_inc),
    .limit   (arb_limit),
    .expired (arb_expired)
  );

  xtm_tick_counter #(.W(XFER_W)) u_xfer_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (xfer_clr),
    .inc     (xfer_inc),
    .limit   (xfer_limit),
    .expired (xfer_expired)
  );

  xtm_phase_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .bus_req      (bus_req),
    .bus_grant    (bus_grant),
    .strobe_any   (strobe_any),
    .xfer_ack     (xfer_ack),
    .arb_en       (arb_en),
    .xfer_en      (xfer_en),
    .arb_expired  (arb_expired),
    .xfer_expired (xfer_expired),
    .status_clr   (status_clr),
    .arb_clr      (arb_clr),
    .arb_inc      (arb_inc),
    .xfer_clr     (xfer_clr),
    .xfer_inc     (xfer_inc),
    .arb_timeout  (arb_timeout),
    .xfer_timeout (xfer_timeout),
    .bus_err      (bus_err),
    .status       (status)
  );

endmodule

// File: rtl/xtm_checker.sv
module xtm_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_req,
  input logic       strobe_a,
  input logic       strobe_b,
  input logic       arb_en,
  input logic       xfer_en,
  input logic [1:0] status_clr,
  input logic       arb_timeout,
  input logic       xfer_timeout,
  input logic       bus_err,
  input logic [1:0] status
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!bus_err && !arb_timeout && !xfer_timeout && status == 2'b00));

  assert_err_single_R10: assert property (@(posedge clk) disable iff (rst)
    bus_err |=> !bus_err);

  assert_arb_flag_cause_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_timeout) |-> (bus_err && status[0]));

  assert_arb_needs_req_R3: assert property (@(posedge clk) disable iff (rst)
    arb_timeout |-> $past(bus_req));

  assert_xfer_flag_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_timeout) |-> (bus_err && status[1]));

  assert_xfer_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    xfer_timeout |-> $past(strobe_a || strobe_b));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(arb_timeout && xfer_timeout));

  assert_arb_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(arb_timeout) |-> $past(arb_en));

  assert_xfer_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(xfer_timeout) |-> $past(xfer_en));

  assert_arb_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status[0] && !status_clr[0]) |=> status[0]);

  assert_xfer_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status[1] && !status_clr[1]) |=> status[1]);

endmodule

bind xfer_timeout_monitor xtm_checker u_xtm_checker (
  .clk          (clk),
  .rst          (rst),
  .bus_req      (bus_req),
  .strobe_a     (strobe_a),
  .strobe_b     (strobe_b),
  .arb_en       (arb_en),
  .xfer_en      (xfer_en),
  .status_clr   (status_clr),
  .arb_timeout  (arb_timeout),
  .xfer_timeout (xfer_timeout),
  .bus_err      (bus_err),
  .status       (status)
);

// File: tb/test_xfer_timeout_monitor.sv
module test_xfer_timeout_monitor;

  localparam int DIV  = 4;
  localparam int AW   = 5;
  localparam int XW   = 4;
  localparam int AMAX = (1 << AW) - 1;
  localparam int XMAX = (1 << XW) - 1;

  localparam int M_IDLE = 0, M_ARB = 1, M_OWN = 2, M_XFER = 3,
                 M_DONE = 4, M_ARB_TO = 5, M_XFER_TO = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_req = 0, bus_grant = 0, strobe_a = 0, strobe_b = 0, xfer_ack = 0;
  logic          arb_en = 1, xfer_en = 1;
  logic [AW-1:0] arb_limit = 3;
  logic [XW-1:0] xfer_limit = 3;
  logic [1:0]    status_clr = 0;
  logic          arb_timeout, xfer_timeout, bus_err;
  logic [1:0]    status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  xfer_timeout_monitor #(.TICK_DIV(DIV), .ARB_W(AW), .XFER_W(XW)) i_xfer_timeout_monitor (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_grant(bus_grant),
    .strobe_a(strobe_a), .strobe_b(strobe_b), .xfer_ack(xfer_ack),
    .arb_en(arb_en), .arb_limit(arb_limit), .xfer_en(xfer_en),
    .xfer_limit(xfer_limit), .status_clr(status_clr),
    .arb_timeout(arb_timeout), .xfer_timeout(xfer_timeout),
    .bus_err(bus_err), .status(status)
  );

  // reference model written from the requirements
  int m_st, m_acnt, m_xcnt, m_pre;
  bit m_tick, m_err, m_af, m_xf;
  bit [1:0] m_stat;
  int n_st, n_acnt, n_xcnt;
  bit n_err, n_af, n_xf, aexp, xexp, sb, afire, xfire;
  bit [1:0] n_stat;

  always @(posedge clk) begin
    if (rst) begin
      m_st = M_IDLE; m_acnt = 0; m_xcnt = 0; m_pre = 0; m_tick = 0;
      m_err = 0; m_af = 0; m_xf = 0; m_stat = 0;
    end else begin
      sb    = strobe_a || strobe_b;
      aexp  = m_acnt >= int'(arb_limit);
      xexp  = m_xcnt >= int'(xfer_limit);
      afire = (m_st == M_ARB) && bus_req && !bus_grant && arb_en && aexp;
      xfire = (m_st == M_XFER) && !xfer_ack && sb && xfer_en && xexp;
      n_st = m_st; n_af = m_af; n_xf = m_xf; n_err = afire || xfire;
      case (m_st)
        M_IDLE:    if (bus_req) n_st = M_ARB;
        M_ARB:     if (!bus_req) n_st = M_IDLE;
                   else if (bus_grant) n_st = M_OWN;
                   else if (afire) begin n_st = M_ARB_TO; n_af = 1; end
        M_ARB_TO:  if (!bus_req) begin n_st = M_IDLE; n_af = 0; end
        M_OWN:     if (!bus_req) n_st = M_IDLE; else if (sb) n_st = M_XFER;
        M_XFER:    if (xfer_ack) n_st = M_DONE;
                   else if (!sb) n_st = bus_req ? M_OWN : M_IDLE;
                   else if (xfire) begin n_st = M_XFER_TO; n_xf = 1; end
        M_DONE:    if (!sb) n_st = bus_req ? M_OWN : M_IDLE;
        M_XFER_TO: if (!sb) begin n_st = bus_req ? M_OWN : M_IDLE; n_xf = 0; end
        default:   n_st = M_IDLE;
      endcase
      n_stat = m_stat & ~status_clr;
      if (afire) n_stat[0] = 1;
      if (xfire) n_stat[1] = 1;
      if (m_st == M_IDLE) n_acnt = 0;
      else if (m_st == M_ARB && m_tick && arb_en && m_acnt < AMAX) n_acnt = m_acnt + 1;
      else n_acnt = m_acnt;
      if (m_st != M_XFER) n_xcnt = 0;
      else if (m_tick && xfer_en && m_xcnt < XMAX) n_xcnt = m_xcnt + 1;
      else n_xcnt = m_xcnt;
      m_tick = (m_pre == DIV - 1);
      m_pre  = m_tick ? 0 : m_pre + 1;
      m_st = n_st; m_acnt = n_acnt; m_xcnt = n_xcnt; m_err = n_err;
      m_af = n_af; m_xf = n_xf; m_stat = n_stat;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(bus_err == m_err, "R10 bus_err", int'(bus_err), int'(m_err));
    chk(arb_timeout == m_af, "R3 arb_timeout", int'(arb_timeout), int'(m_af));
    chk(xfer_timeout == m_xf, "R5 xfer_timeout", int'(xfer_timeout), int'(m_xf));
    chk(status == m_stat, "R8 status", int'(status), int'(m_stat));
  endtask

  task automatic step();
    @(negedge clk);
    if (!rst) compare_all();
  endtask

  task automatic idle_inputs();
    bus_req = 0; bus_grant = 0; strobe_a = 0; strobe_b = 0; xfer_ack = 0;
    status_clr = 2'b11; arb_en = 1; xfer_en = 1;
    repeat (2) step();
    status_clr = 0;
    step();
  endtask

  // cycles from the edge that first samples the request until bus_err is seen
  task automatic measure_arb(input int lim, output int k);
    arb_limit = AW'(lim); bus_grant = 0; bus_req = 1;
    k = 0;
    do begin step(); k++; end while (!bus_err && k < 200);
  endtask

  initial begin
    int k, errs;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(bus_err == 0 && arb_timeout == 0 && xfer_timeout == 0 && status == 0,
        "R1 reset outputs", int'({arb_timeout, xfer_timeout, bus_err, status}), 0);
    rst = 0;
    idle_inputs();

    // R2 / R3: arbitration expiry latency within the tick window
    measure_arb(3, k);
    chk(k >= 2 * DIV + 3 && k <= 3 * DIV + 2, "R2 arb latency", k, 3 * DIV + 2);
    chk(status == 2'b01 && arb_timeout, "R3 arb timeout state",
        int'({arb_timeout, status}), 5);
    repeat (5) step();
    chk(arb_timeout == 1, "R3 flag held while requesting", int'(arb_timeout), 1);
    bus_req = 0; step(); step();
    chk(arb_timeout == 0, "R3 flag cleared on release", int'(arb_timeout), 0);

    // R8: write-one-to-clear
    status_clr = 2'b01; step(); status_clr = 0; step();
    chk(status == 2'b00, "R8 w1c clears", int'(status), 0);

    // R9: second request gets the full window again
    measure_arb(4, k);
    chk(k >= 3 * DIV + 3 && k <= 4 * DIV + 2, "R9 counter restarted", k, 4 * DIV + 2);
    idle_inputs();

    // R4: grant in the very cycle of expiry
    arb_limit = 2; bus_req = 1;
    k = 0;
    do begin step(); k++; end while (!(m_st == M_ARB && m_acnt >= 2) && k < 100);
    bus_grant = 1; step();
    chk(!bus_err && !arb_timeout && status[0] == 0, "R4 grant wins race",
        int'({bus_err, arb_timeout, status[0]}), 0);

    // R6: acknowledge in the very cycle of transfer expiry
    xfer_limit = 2; strobe_a = 1;
    k = 0;
    do begin step(); k++; end while (!(m_st == M_XFER && m_xcnt >= 2) && k < 100);
    xfer_ack = 1; step(); xfer_ack = 0;
    chk(!bus_err && !xfer_timeout && status[1] == 0, "R6 ack wins race",
        int'({bus_err, xfer_timeout, status[1]}), 0);
    strobe_a = 0; step();

    // R5: transfer expiry on the second strobe, flag held until strobes fall
    xfer_limit = 3; strobe_b = 1;
    k = 0;
    do begin step(); k++; end while (!bus_err && k < 100);
    chk(k >= 2 * DIV + 3 && k <= 3 * DIV + 2, "R5 transfer latency", k, 3 * DIV + 2);
    chk(status[1] && xfer_timeout, "R5 transfer timeout state",
        int'({xfer_timeout, status[1]}), 3);
    strobe_b = 0; step(); step();
    chk(xfer_timeout == 0, "R5 flag cleared with strobes", int'(xfer_timeout), 0);
    idle_inputs();

    // R7: disabled phases never expire
    arb_en = 0; arb_limit = 1; bus_req = 1; errs = 0;
    repeat (20 * DIV) begin step(); if (bus_err) errs++; end
    chk(errs == 0 && status == 0, "R7 arb disabled", errs, 0);
    arb_en = 1; bus_grant = 1; xfer_en = 0; xfer_limit = 1; strobe_a = 1;
    repeat (20 * DIV) begin step(); if (bus_err) errs++; end
    chk(errs == 0 && status == 0 && !xfer_timeout, "R7 xfer disabled", errs, 0);
    idle_inputs();

    // R1: reset in the middle of activity
    bus_req = 1; arb_limit = 1;
    repeat (3 * DIV) step();
    rst = 1; step();
    chk(bus_err == 0 && arb_timeout == 0 && xfer_timeout == 0 && status == 0,
        "R1 mid-run reset", int'({arb_timeout, xfer_timeout, bus_err, status}), 0);
    rst = 0; bus_req = 0;
    idle_inputs();

    // constrained random traffic against the model
    for (int i = 0; i < 8000; i++) begin
      if ($urandom % 48 == 0) bus_req = ~bus_req;
      if ($urandom % 12 == 0) bus_grant = ~bus_grant;
      if ($urandom % 14 == 0) strobe_a = ~strobe_a;
      if ($urandom % 22 == 0) strobe_b = ~strobe_b;
      xfer_ack   = ($urandom % 10 == 0);
      status_clr = ($urandom % 16 == 0) ? 2'($urandom % 4) : 2'b00;
      if ($urandom % 300 == 0) arb_en = ~arb_en;
      if ($urandom % 300 == 0) xfer_en = ~xfer_en;
      if ($urandom % 150 == 0) arb_limit = AW'($urandom % 14);
      if ($urandom % 150 == 0) xfer_limit = XW'($urandom % 12);
      if ($urandom % 2000 == 0) arb_limit = AW'(AMAX);
      step();
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule